// File: doc/BRIEF.md
# Machine-Mode Interrupt Controller with Local Timer

This block sits beside the pipeline of a small 32-bit RISC-V core. It runs machine-mode interrupt handling and holds the control and status registers involved: the global status bits, the per-source enables, the read-only pending word, the trap base, the saved return address and the cause. It also has a local timer, a free-running 32-bit count with a 32-bit compare value. Both timer registers are reached through two custom CSR numbers, not through a memory map. A single external interrupt line enters through a two-flop synchronizer.

Each cycle the unit decides whether an enabled, pending interrupt must be taken. When one is, it raises a redirect toward the trap base and saves the PC of the oldest instruction that has not completed. On the same clock edge it records the cause and pushes the global enable onto a one-deep stack. An `mret` strobe from the pipeline pops that stack, and the pipeline resumes at the saved address, which the unit presents on its own output. Vectoring is direct only: every trap lands on the same base address.

Top module: `mtrap_unit`

## Requirements
- R1: The enable word (CSR 0x304) keeps only bit 7 (timer enable) and bit 11 (external enable). Every other bit reads back as zero.
- R2: The pending word (CSR 0x344) shows the timer-pending flag in bit 7 and the external-pending flag in bit 11. Writes to it change nothing.
- R3: While the global enable (status bit 3) or the source's own enable is clear, a pending source stays visible in the pending word and no trap is raised.
- R4: `trap_take_o` is high exactly when the global enable is set and at least one source is both pending and enabled. While it is high, `trap_pc_o` equals the trap base.
- R5: On trap entry the global enable is cleared and its previous value moves into status bit 7. On `mret`, bit 7 returns into the global enable and bit 7 is then set.
- R6: The cause register (CSR 0x342) receives 0x8000_0007 for a timer interrupt and 0x8000_000B for an external interrupt.
- R7: The count (CSR 0x7C0) rises by one every cycle unless it is written, and the compare value (CSR 0x7C1) resets to all ones. Timer-pending holds while count >= compare.
- R8: External-pending follows the interrupt pin two clock edges later and is level-sensitive, so it falls again when the pin falls.
- R9: The trap base (CSR 0x305) and the saved PC (CSR 0x341) store bits 31..2 and read zero in bits 1..0. Every trap uses that one base address.
- R10: When both sources are pending and enabled in the same cycle, the external interrupt is taken first.
- R11: On trap entry the saved PC captures `retire_pc_i`, which is the address of the first instruction that did not complete. `mepc_o` presents it for the return.
- R12: A CSR write issued in the same cycle as a trap entry is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 12 | CSR number for read and write |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data for `csr_addr_i` (combinational) |
| irq_ext_i | input | 1 | Asynchronous external interrupt level |
| retire_pc_i | input | 32 | PC of the oldest instruction that has not completed |
| mret_i | input | 1 | Return-from-trap strobe |
| trap_take_o | output | 1 | Interrupt taken this cycle; redirect fetch |
| trap_pc_o | output | 32 | Redirect target (the trap base) |
| mepc_o | output | 32 | Saved return address for `mret` |

## Verification
The assertions assume the pipeline sends no `mret` in the same cycle as a trap entry. If it does, the entry wins, and the property on the restore is guarded to allow for that. They also assume `irq_ext_i` stays low during reset. The bench drives every input on the falling edge, keeps the interrupt pin low through reset, and pulses `mret_i` only while the global enable is clear and nothing can be taken, so it stays inside these assumptions.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
  localparam int XLEN = 32;

  localparam logic [11:0] A_STATUS = 12'h300;
  localparam logic [11:0] A_ENABLE = 12'h304;
  localparam logic [11:0] A_TBASE  = 12'h305;
  localparam logic [11:0] A_EPC    = 12'h341;
  localparam logic [11:0] A_CAUSE  = 12'h342;
  localparam logic [11:0] A_PEND   = 12'h344;
  localparam logic [11:0] A_TCOUNT = 12'h7C0;
  localparam logic [11:0] A_TCMP   = 12'h7C1;

  localparam int GIE_BIT  = 3;
  localparam int PGIE_BIT = 7;
  localparam int TMR_BIT  = 7;
  localparam int EXT_BIT  = 11;

  localparam logic [XLEN-1:0] CAUSE_TMR = 32'h8000_0007;
  localparam logic [XLEN-1:0] CAUSE_EXT = 32'h8000_000B;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_TIMER = 2'd1,
    SRC_EXTRN = 2'd2
  } irq_src_e;

  function automatic logic timer_due(input logic [XLEN-1:0] cnt,
                                     input logic [XLEN-1:0] cmp);
    return cnt >= cmp;
  endfunction

  function automatic logic [XLEN-1:0] src_word(input logic tmr, input logic ext);
    logic [XLEN-1:0] w;
    w = '0;
    w[TMR_BIT] = tmr;
    w[EXT_BIT] = ext;
    return w;
  endfunction

  function automatic logic [XLEN-1:0] cause_of(input irq_src_e s);
    return (s == SRC_EXTRN) ? CAUSE_EXT : CAUSE_TMR;
  endfunction
endpackage

// File: rtl/mtrap_sync.sv
module mtrap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mtrap_timer.sv
module mtrap_timer
  import mtrap_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_we_i,
  input  logic         cmp_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] cmp_o,
  output logic         due_o
);
  logic [W-1:0] count_q, cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      cmp_q   <= '1;
    end else begin
      count_q <= cnt_we_i ? wdata_i : count_q + 1'b1;
      if (cmp_we_i) cmp_q <= wdata_i;
    end
  end

  assign count_o = count_q;
  assign cmp_o   = cmp_q;
  assign due_o   = timer_due(count_q, cmp_q);
endmodule

// File: rtl/mtrap_arb.sv
module mtrap_arb
  import mtrap_pkg::*;
(
  input  logic     gie_i,
  input  logic     tmr_en_i,
  input  logic     ext_en_i,
  input  logic     tmr_pend_i,
  input  logic     ext_pend_i,
  output logic     take_o,
  output irq_src_e src_o
);
  logic tmr_rdy, ext_rdy;

  assign tmr_rdy = tmr_en_i & tmr_pend_i;
  assign ext_rdy = ext_en_i & ext_pend_i;

  always_comb begin
    src_o = SRC_NONE;
    if (ext_rdy)      src_o = SRC_EXTRN;
    else if (tmr_rdy) src_o = SRC_TIMER;
  end

  assign take_o = gie_i & (tmr_rdy | ext_rdy);
endmodule

// File: rtl/mtrap_unit.sv
module mtrap_unit
  import mtrap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we_i,
  input  logic [11:0] csr_addr_i,
  input  logic [31:0] csr_wdata_i,
  output logic [31:0] csr_rdata_o,
  input  logic        irq_ext_i,
  input  logic [31:0] retire_pc_i,
  input  logic        mret_i,
  output logic        trap_take_o,
  output logic [31:0] trap_pc_o,
  output logic [31:0] mepc_o
);
  logic            gie_q, pgie_q;
  logic            tmr_en_q, ext_en_q;
  logic [XLEN-1:2] tbase_q, epc_q;
  logic [XLEN-1:0] cause_q;

  logic            tmr_pend_w, ext_pend_w;
  logic            take_w, wr_ok_w;
  irq_src_e        src_w;
  logic [XLEN-1:0] count_w, cmp_w;

  assign wr_ok_w = csr_we_i & ~take_w;

  mtrap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (irq_ext_i),
    .q_o   (ext_pend_w)
  );

  mtrap_timer #(.W(XLEN)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_we_i (wr_ok_w && csr_addr_i == A_TCOUNT),
    .cmp_we_i (wr_ok_w && csr_addr_i == A_TCMP),
    .wdata_i  (csr_wdata_i),
    .count_o  (count_w),
    .cmp_o    (cmp_w),
    .due_o    (tmr_pend_w)
  );

  mtrap_arb u_arb (
    .gie_i      (gie_q),
    .tmr_en_i   (tmr_en_q),
    .ext_en_i   (ext_en_q),
    .tmr_pend_i (tmr_pend_w),
    .ext_pend_i (ext_pend_w),
    .take_o     (take_w),
    .src_o      (src_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q    <= 1'b0;
      pgie_q   <= 1'b0;
      tmr_en_q <= 1'b0;
      ext_en_q <= 1'b0;
      tbase_q  <= '0;
      epc_q    <= '0;
      cause_q  <= '0;
    end else if (take_w) begin
      pgie_q  <= gie_q;
      gie_q   <= 1'b0;
      epc_q   <= retire_pc_i[XLEN-1:2];
      cause_q <= cause_of(src_w);
    end else begin
      if (mret_i) begin
        gie_q  <= pgie_q;
        pgie_q <= 1'b1;
      end else if (wr_ok_w && csr_addr_i == A_STATUS) begin
        gie_q  <= csr_wdata_i[GIE_BIT];
        pgie_q <= csr_wdata_i[PGIE_BIT];
      end
      if (wr_ok_w) begin
        unique case (csr_addr_i)
          A_ENABLE: begin
            tmr_en_q <= csr_wdata_i[TMR_BIT];
            ext_en_q <= csr_wdata_i[EXT_BIT];
          end
          A_TBASE: tbase_q <= csr_wdata_i[XLEN-1:2];
          A_EPC:   epc_q   <= csr_wdata_i[XLEN-1:2];
          A_CAUSE: cause_q <= csr_wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    csr_rdata_o = '0;
    unique case (csr_addr_i)
      A_STATUS: begin
        csr_rdata_o[GIE_BIT]  = gie_q;
        csr_rdata_o[PGIE_BIT] = pgie_q;
      end
      A_ENABLE: csr_rdata_o = src_word(tmr_en_q, ext_en_q);
      A_PEND:   csr_rdata_o = src_word(tmr_pend_w, ext_pend_w);
      A_TBASE:  csr_rdata_o = {tbase_q, 2'b00};
      A_EPC:    csr_rdata_o = {epc_q, 2'b00};
      A_CAUSE:  csr_rdata_o = cause_q;
      A_TCOUNT: csr_rdata_o = count_w;
      A_TCMP:   csr_rdata_o = cmp_w;
      default:  csr_rdata_o = '0;
    endcase
  end

  assign trap_take_o = take_w;
  assign trap_pc_o   = {tbase_q, 2'b00};
  assign mepc_o      = {epc_q, 2'b00};
endmodule

// File: rtl/mtrap_unit_chk.sv
module mtrap_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        take,
  input logic        gie,
  input logic        pgie,
  input logic        tmr_en,
  input logic        ext_en,
  input logic        tmr_pend,
  input logic        ext_pend,
  input logic        mret,
  input logic [31:0] cause,
  input logic [31:0] trap_pc,
  input logic [31:0] epc,
  input logic [31:0] retire_pc
);
  // R3
  masked_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !take);

  // R4
  take_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ((tmr_en && tmr_pend) || (ext_en && ext_pend)));

  // R5
  entry_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!gie && pgie == $past(gie)));

  // R5
  mret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mret && !take) |=> (gie == $past(pgie) && pgie));

  // R6
  cause_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (cause == 32'h8000_0007 || cause == 32'h8000_000B));

  // R10
  ext_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ext_en && ext_pend) |=> cause == 32'h8000_000B);

  // R11
  epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> epc == {$past(retire_pc[31:2]), 2'b00});

  // R9
  base_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pc[1:0] == 2'b00);
endmodule

bind mtrap_unit mtrap_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .take      (trap_take_o),
  .gie       (gie_q),
  .pgie      (pgie_q),
  .tmr_en    (tmr_en_q),
  .ext_en    (ext_en_q),
  .tmr_pend  (tmr_pend_w),
  .ext_pend  (ext_pend_w),
  .mret      (mret_i),
  .cause     (cause_q),
  .trap_pc   (trap_pc_o),
  .epc       (mepc_o),
  .retire_pc (retire_pc_i)
);

// File: tb/mtrap_unit_bench.sv
module mtrap_unit_bench;
  localparam int PERIOD = 10;
  localparam int NVEC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        irq = 1'b0;
  logic [31:0] rpc = '0;
  logic        mret = 1'b0;
  logic        take;
  logic [31:0] tpc, epc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // {addr, write data, expected readback}
  localparam logic [75:0] VECS [NVEC] = '{
    {12'h304, 32'hFFFF_FFFF, 32'h0000_0880},  // R1
    {12'h344, 32'hFFFF_FFFF, 32'h0000_0000},  // R2
    {12'h305, 32'h0000_1003, 32'h0000_1000},  // R9
    {12'h341, 32'h0000_2003, 32'h0000_2000},  // R9
    {12'h342, 32'h8000_000B, 32'h8000_000B},
    {12'h7C1, 32'h0000_1234, 32'h0000_1234},  // R7
    {12'h300, 32'hFFFF_FFFF, 32'h0000_0088},  // R5 field layout
    {12'h300, 32'h0000_0000, 32'h0000_0000}
  };

  always #(PERIOD/2) clk = ~clk;

  mtrap_unit u_mtrap_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_we_i    (csr_we),
    .csr_addr_i  (csr_addr),
    .csr_wdata_i (csr_wdata),
    .csr_rdata_o (csr_rdata),
    .irq_ext_i   (irq),
    .retire_pc_i (rpc),
    .mret_i      (mret),
    .trap_take_o (take),
    .trap_pc_o   (tpc),
    .mepc_o      (epc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    csr_addr = a;
    #1;
    check(req, csr_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    rd_chk("R5 reset status", 12'h300, 32'h0);
    rd_chk("R1 reset enable", 12'h304, 32'h0);
    rd_chk("R7 reset compare", 12'h7C1, 32'hFFFF_FFFF);
    check("R4 reset take", {31'b0, take}, 32'h0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      wr(VECS[i][75:64], VECS[i][63:32]);
      rd_chk("R1/R2/R7/R9 vector", VECS[i][75:64], VECS[i][31:0]);
    end

    // R7: free-running count
    wr(12'h7C0, 32'h0000_0100);
    rd_chk("R7 count load", 12'h7C0, 32'h0000_0100);
    repeat (5) @(negedge clk);
    rd_chk("R7 count advance", 12'h7C0, 32'h0000_0105);

    // R3: timer pending while globally masked
    wr(12'h7C1, 32'h0000_0010);
    wr(12'h7C0, 32'h0000_0020);
    rd_chk("R3 masked pending visible", 12'h344, 32'h0000_0080);
    repeat (3) @(negedge clk);
    check("R3 masked no take", {31'b0, take}, 32'h0);

    // R4/R5/R6/R11: timer taken
    rpc = 32'h0000_0400;
    wr(12'h300, 32'h0000_0008);
    check("R4 take raised", {31'b0, take}, 32'h1);
    check("R4 redirect to base", tpc, 32'h0000_1000);
    @(negedge clk);
    rd_chk("R6 timer cause", 12'h342, 32'h8000_0007);
    rd_chk("R5 entry stacking", 12'h300, 32'h0000_0080);
    check("R11 saved pc", epc, 32'h0000_0400);
    check("R5 no take after entry", {31'b0, take}, 32'h0);

    // handler clears timer and returns
    wr(12'h7C1, 32'hFFFF_FFFF);
    rd_chk("R7 pending cleared by compare", 12'h344, 32'h0);
    mret = 1'b1;
    @(negedge clk);
    mret = 1'b0;
    rd_chk("R5 mret restore", 12'h300, 32'h0000_0088);

    // R8: external through synchronizer
    wr(12'h304, 32'h0000_0800);
    rpc = 32'h0000_0500;
    irq = 1'b1;
    csr_addr = 12'h344;
    @(negedge clk);
    rd_chk("R8 one edge not yet", 12'h344, 32'h0);
    check("R8 no take yet", {31'b0, take}, 32'h0);
    @(negedge clk);
    rd_chk("R8 two edges pending", 12'h344, 32'h0000_0800);
    check("R8 take on external", {31'b0, take}, 32'h1);
    @(negedge clk);
    rd_chk("R6 external cause", 12'h342, 32'h8000_000B);
    check("R11 saved pc external", epc, 32'h0000_0500);
    irq = 1'b0;
    repeat (2) @(negedge clk);
    rd_chk("R8 level follows pin", 12'h344, 32'h0);

    // R12: write in trap-entry cycle dropped; R10 priority
    wr(12'h304, 32'h0000_0880);
    wr(12'h7C1, 32'h0000_0000);
    irq = 1'b1;
    repeat (2) @(negedge clk);
    rd_chk("R3 both pending masked", 12'h344, 32'h0000_0880);
    check("R3 both masked no take", {31'b0, take}, 32'h0);
    wr(12'h300, 32'h0000_0008);
    check("R10 take with both", {31'b0, take}, 32'h1);
    wr(12'h305, 32'h0000_3000);
    rd_chk("R10 external first", 12'h342, 32'h8000_000B);
    rd_chk("R12 write dropped at entry", 12'h305, 32'h0000_1000);
    irq = 1'b0;
    repeat (2) @(negedge clk);

    finish_run();
  end
endmodule